// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers the event indications of one serial receive/transmit channel into a 16-bit status word. Each event position is sticky: once an event occurs its bit stays set until the host reads the status word, and that read clears everything that was set. A second host-visible word holds an enable mask. The single interrupt request to the host is the registered OR of the status bits that are also enabled.

Some events arrive as one-cycle pulses from neighbouring logic (parity and receive errors, self-test error, schedule marker, asynchronous word sent) and are latched as they come. Others are derived inside the block from raw state. A word arriving at an empty, non-full receive FIFO flags data available. A word arriving at a full receive FIFO flags an overflow. The rising edges of the FIFO level flags are latched. The fall of the transmitter-running flag flags transmit complete.

The host port is a plain single-cycle register interface. Read data is registered and appears the cycle after the read strobe. Address 0 selects the status word and address 1 selects the enable word.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word, the enable word, the read data and the interrupt request are all zero.
- R2: Pulse inputs latch into fixed positions and stay set until a clearing read: parity error bit 7, receive error bit 8, self-test error bit 9, schedule marker bit 10, asynchronous word sent bit 11. Bits 6, 13, 14 and 15 always read 0.
- R3: Bit 0 (receive data available) sets only when a word arrives while the receive FIFO is empty and not full. A word arriving at a non-empty FIFO leaves it clear.
- R4: Bit 3 (receive overflow) sets when a word arrives while the receive FIFO is full.
- R5: Bit 12 (transmit complete) sets on a high-to-low transition of the transmitter-running input. A rise, or a steady high or low, sets nothing.
- R6: Bits 1 (receive almost full), 2 (receive full), 4 (transmit empty) and 5 (transmit almost empty) set on the rising edge of their level flag. A flag that stays high after a clearing read does not set its bit again.
- R7: A read at address 0 returns the status word on the next cycle and clears every set bit at that same edge.
- R8: An event that occurs in the same cycle as a clearing read is kept, and the following read returns it.
- R9: Address 1 is the read/write enable word. Only the valid event positions (mask 0x1FBF) are stored, and the other bits read 0.
- R10: The interrupt request goes high one cycle after a status bit and its enable bit are both set, and falls one cycle after a clearing read. Status bits latch whether or not they are enabled.
- R11: Writes to address 0 do not change the status word. Reads at addresses other than 0 and 1 return 0 and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Host write strobe |
| reg_rd_en | input | 1 | Host read strobe |
| reg_addr | input | ADDR_W | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered host read data |
| rx_word_in | input | 1 | Pulse: a received word is offered to the receive FIFO |
| rx_fifo_empty | input | 1 | Receive FIFO empty level |
| rx_fifo_afull | input | 1 | Receive FIFO almost-full level |
| rx_fifo_full | input | 1 | Receive FIFO full level |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_fifo_aempty | input | 1 | Transmit FIFO almost-empty level |
| tx_running | input | 1 | Transmitter busy level |
| ev_parity | input | 1 | Pulse: parity error |
| ev_rx_err | input | 1 | Pulse: receive error |
| ev_selftest | input | 1 | Pulse: self-test error |
| ev_sched | input | 1 | Pulse: schedule interrupt marker |
| ev_async_sent | input | 1 | Pulse: asynchronous word sent |
| irq | output | 1 | Registered interrupt request |

## Verification
A status bit that fails to stick, or that is wrongly set, appears in the very next status read. A lost same-cycle event shows as a zero in the read that follows the clearing read. A stale edge-detector history creates a spurious bit, or misses one, within a single cycle of the flag changing, so each edge scenario reads back right after the stimulus. A bad enable mask or a bad request register shows on `irq` exactly one cycle after the status change or the clearing read, so the request is sampled on both of those cycles.

// File: rtl/irq_pkg.sv
// Package: shared widths, bit positions and masks of the interrupt status word.
// Assumes a 16-bit status word whose bit positions are fixed by the host software.
package irq_pkg;
    localparam int STAT_W = 16;
    typedef logic [STAT_W-1:0] stat_t;

    localparam int B_RX_AVAIL   = 0;
    localparam int B_RX_AFULL   = 1;
    localparam int B_RX_FULL    = 2;
    localparam int B_RX_OVF     = 3;
    localparam int B_TX_EMPTY   = 4;
    localparam int B_TX_AEMPTY  = 5;
    localparam int B_PARITY     = 7;
    localparam int B_RX_ERR     = 8;
    localparam int B_SELFTEST   = 9;
    localparam int B_SCHED      = 10;
    localparam int B_ASYNC_SENT = 11;
    localparam int B_TX_DONE    = 12;

    localparam int N_LVL   = 4;   // level flags latched on their rising edge
    localparam int N_PULSE = 5;   // pulse inputs latched directly

    localparam stat_t VALID_MASK = 16'h1FBF;

    // Status position of the i-th rising-edge level flag.
    function automatic int lvl_pos(input int i);
        case (i)
            0:       return B_RX_AFULL;
            1:       return B_RX_FULL;
            2:       return B_TX_EMPTY;
            default: return B_TX_AEMPTY;
        endcase
    endfunction

    // Status position of the i-th pulse input (bits 7..11 in order).
    function automatic int pulse_pos(input int i);
        return B_PARITY + i;
    endfunction
endpackage

// File: rtl/irq_edge_det.sv
// Module: per-bit edge detector for level signals.
// Produces a one-cycle pulse, aligned with the input, on a rising (RISE=1) or
// falling (RISE=0) transition. The history register resets to RST_VAL so that
// the level present right after reset is not taken for an edge.
module irq_edge_det #(
    parameter int         W       = 1,
    parameter bit         RISE    = 1'b1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] edge_pulse
);
    logic [W-1:0] hist_q;

    // Keep last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= RST_VAL;
        else        hist_q <= lvl;
    end

    generate
        if (RISE) begin : g_rise
            // Rising transition: low last cycle, high now.
            always_comb edge_pulse = lvl & ~hist_q;
        end else begin : g_fall
            // Falling transition: high last cycle, low now.
            always_comb edge_pulse = hist_q & ~lvl;
        end
    endgenerate
endmodule

// File: rtl/irq_event_map.sv
// Module: turns raw FIFO/transmitter state and event pulses into a vector of
// one-cycle events placed at their status positions.
// Assumes rx_word_in is a one-cycle strobe and that the FIFO flags describe the
// FIFO state before the offered word is accepted.
module irq_event_map
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_word_in,
    input  logic  rx_fifo_empty,
    input  logic  rx_fifo_afull,
    input  logic  rx_fifo_full,
    input  logic  tx_fifo_empty,
    input  logic  tx_fifo_aempty,
    input  logic  tx_running,
    input  logic  [N_PULSE-1:0] pulses,
    output stat_t evt_vec
);
    logic [N_LVL-1:0] lvl_raw;
    logic [N_LVL-1:0] lvl_rise;
    logic             tx_fall;
    logic             word_to_empty;
    logic             word_dropped;

    // Gather the level flags in the order used by lvl_pos().
    always_comb lvl_raw = {tx_fifo_aempty, tx_fifo_empty, rx_fifo_full, rx_fifo_afull};

    irq_edge_det #(
        .W       (N_LVL),
        .RISE    (1'b1),
        .RST_VAL ({N_LVL{1'b1}})
    ) u_lvl_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl_raw),
        .edge_pulse (lvl_rise)
    );

    irq_edge_det #(
        .W       (1),
        .RISE    (1'b0),
        .RST_VAL (1'b0)
    ) u_tx_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (tx_running),
        .edge_pulse (tx_fall)
    );

    // Qualify incoming words against the receive FIFO state.
    always_comb begin
        word_to_empty = rx_word_in & rx_fifo_empty & ~rx_fifo_full;
        word_dropped  = rx_word_in & rx_fifo_full;
    end

    // Place every event at its status position.
    always_comb begin
        evt_vec = '0;
        evt_vec[B_RX_AVAIL] = word_to_empty;
        evt_vec[B_RX_OVF]   = word_dropped;
        evt_vec[B_TX_DONE]  = tx_fall;
        for (int i = 0; i < N_LVL; i++)   evt_vec[lvl_pos(i)]   = lvl_rise[i];
        for (int j = 0; j < N_PULSE; j++) evt_vec[pulse_pos(j)] = pulses[j];
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module: sticky status register. New events OR into the stored bits; a clear
// request wipes the stored bits at the same edge, but events arriving in that
// cycle are kept. Reserved positions are forced to zero.
module irq_status_reg
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t evt_vec,
    input  logic  clr,
    output stat_t status_q
);
    stat_t status_d;

    // Next state: old bits unless cleared, plus this cycle's events.
    always_comb status_d = ((clr ? '0 : status_q) | evt_vec) & VALID_MASK;

    // Hold the sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/irq_host_port.sv
// Module: host register port, enable mask and interrupt request.
// Address 0 reads (and clears) status, address 1 is the read/write enable word.
// Read data is registered; the request is registered from status AND enable.
module irq_host_port
    import irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  stat_t             wdata,
    input  stat_t             status_q,
    output logic              clr_status,
    output stat_t             enable_q,
    output stat_t             rdata_q,
    output logic              irq_q
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(1);

    stat_t rd_mux;

    // A read of the status address requests a clear.
    always_comb clr_status = rd_en && (addr == A_STATUS);

    // Select read data by address; unmapped addresses read zero.
    always_comb begin
        case (addr)
            A_STATUS: rd_mux = status_q;
            A_ENABLE: rd_mux = enable_q;
            default:  rd_mux = '0;
        endcase
    end

    // Enable word: writable, only valid positions stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                         enable_q <= '0;
        else if (wr_en && addr == A_ENABLE) enable_q <= wdata & VALID_MASK;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & enable_q);
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the latched interrupt status controller for one channel.
// Connects event derivation, the sticky status word and the host port.
// Assumes a single clock domain; all inputs are synchronous to clk.
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              rx_word_in,
    input  logic              rx_fifo_empty,
    input  logic              rx_fifo_afull,
    input  logic              rx_fifo_full,
    input  logic              tx_fifo_empty,
    input  logic              tx_fifo_aempty,
    input  logic              tx_running,
    input  logic              ev_parity,
    input  logic              ev_rx_err,
    input  logic              ev_selftest,
    input  logic              ev_sched,
    input  logic              ev_async_sent,
    output logic              irq
);
    stat_t             evt_vec;
    stat_t             status_q;
    stat_t             enable_q;
    stat_t             rdata_q;
    logic              clr_status;
    logic              irq_q;
    logic [N_PULSE-1:0] pulses;

    // Pulse inputs in status-position order (bits 7..11).
    always_comb pulses = {ev_async_sent, ev_sched, ev_selftest, ev_rx_err, ev_parity};

    irq_event_map u_map (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_word_in     (rx_word_in),
        .rx_fifo_empty  (rx_fifo_empty),
        .rx_fifo_afull  (rx_fifo_afull),
        .rx_fifo_full   (rx_fifo_full),
        .tx_fifo_empty  (tx_fifo_empty),
        .tx_fifo_aempty (tx_fifo_aempty),
        .tx_running     (tx_running),
        .pulses         (pulses),
        .evt_vec        (evt_vec)
    );

    irq_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_vec  (evt_vec),
        .clr      (clr_status),
        .status_q (status_q)
    );

    irq_host_port #(.ADDR_W(ADDR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .status_q   (status_q),
        .clr_status (clr_status),
        .enable_q   (enable_q),
        .rdata_q    (rdata_q),
        .irq_q      (irq_q)
    );

    // Drive the outputs from the registered values.
    always_comb begin
        reg_rdata = rdata_q;
        irq       = irq_q;
    end
endmodule

// File: rtl/irq_status_chk.sv
// Checker: temporal properties of the status controller, bound to the top.
module irq_status_chk
    import irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              rx_word_in,
    input logic              rx_fifo_empty,
    input logic              rx_fifo_full,
    input logic              tx_running,
    input logic              irq,
    input stat_t             status,
    input stat_t             enable,
    input stat_t             events
);
    logic clr_rd;
    always_comb clr_rd = reg_rd_en && (reg_addr == '0);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~VALID_MASK) == '0);

    assert_sticky_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_rd |=> ((status & $past(status)) == $past(status)));

    assert_avail_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_RX_AVAIL]) |-> $past(rx_word_in && rx_fifo_empty && !rx_fifo_full));

    assert_no_overflow_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_in && rx_fifo_full) |=> status[B_RX_OVF]);

    assert_tx_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_running) |=> status[B_TX_DONE]);

    assert_clear_keeps_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |=> (status == $past(events & VALID_MASK)));

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((status & enable) != '0));

    assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past((status & enable) == '0));
endmodule

bind irq_status_ctrl irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rd_en     (reg_rd_en),
    .reg_addr      (reg_addr),
    .rx_word_in    (rx_word_in),
    .rx_fifo_empty (rx_fifo_empty),
    .rx_fifo_full  (rx_fifo_full),
    .tx_running    (tx_running),
    .irq           (irq),
    .status        (status_q),
    .enable        (enable_q),
    .events        (evt_vec)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 0, reg_rd_en = 0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_word_in = 0, rx_fifo_empty = 0, rx_fifo_afull = 0, rx_fifo_full = 0;
    logic        tx_fifo_empty = 0, tx_fifo_aempty = 0, tx_running = 0;
    logic        ev_parity = 0, ev_rx_err = 0, ev_selftest = 0, ev_sched = 0, ev_async_sent = 0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    irq_status_ctrl #(.ADDR_W(2)) u0 (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled 1 ns after it.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_rd_en = 1; reg_addr = a;
        tick();
        v = reg_rdata;
        reg_rd_en = 0; reg_addr = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rdata", reg_rdata, 16'h0);
        check("R1 irq", {15'b0, irq}, 16'h0);
        rd(2'd0, v); check("R1 status", v, 16'h0);
        rd(2'd1, v); check("R1 enable", v, 16'h0);
    endtask

    task automatic t_pulses();
        logic [15:0] v;
        ev_parity = 1; tick(); ev_parity = 0;
        repeat (3) tick();
        rd(2'd0, v); check("R2 parity held", v, 16'h0080);
        rd(2'd0, v); check("R7 cleared", v, 16'h0000);
        {ev_parity, ev_rx_err, ev_selftest, ev_sched, ev_async_sent} = '1;
        tick();
        {ev_parity, ev_rx_err, ev_selftest, ev_sched, ev_async_sent} = '0;
        rd(2'd0, v); check("R2 all pulses, reserved zero", v, 16'h0F80);
    endtask

    task automatic t_avail();
        logic [15:0] v;
        rx_fifo_empty = 1; rx_word_in = 1; tick(); rx_word_in = 0; rx_fifo_empty = 0;
        rd(2'd0, v); check("R3 word into empty", v, 16'h0001);
        rx_word_in = 1; tick(); rx_word_in = 0;
        rd(2'd0, v); check("R3 word into non-empty", v, 16'h0000);
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        rx_fifo_full = 1; tick();
        rx_word_in = 1; tick(); rx_word_in = 0;
        rd(2'd0, v); check("R4 overflow plus full edge", v, 16'h000C);
        repeat (3) tick();
        rd(2'd0, v); check("R6 full held, no re-set", v, 16'h0000);
        rx_fifo_full = 0; tick();
    endtask

    task automatic t_levels();
        logic [15:0] v;
        rx_fifo_afull = 1; tick();
        tx_fifo_empty = 1; tick();
        tx_fifo_aempty = 1; tick();
        rd(2'd0, v); check("R6 level rises", v, 16'h0032);
        rx_fifo_afull = 0; tx_fifo_empty = 0; tx_fifo_aempty = 0; tick();
        rd(2'd0, v); check("R6 falls ignored", v, 16'h0000);
    endtask

    task automatic t_txdone();
        logic [15:0] v;
        tx_running = 1; repeat (3) tick();
        rd(2'd0, v); check("R5 rise ignored", v, 16'h0000);
        tx_running = 0; tick();
        rd(2'd0, v); check("R5 fall sets", v, 16'h1000);
        repeat (2) tick();
        rd(2'd0, v); check("R5 steady low", v, 16'h0000);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        ev_parity = 1; tick(); ev_parity = 0;
        ev_sched = 1; rd(2'd0, v); ev_sched = 0;
        check("R7 read returns pre-clear", v, 16'h0080);
        rd(2'd0, v); check("R8 same-cycle event kept", v, 16'h0400);
    endtask

    task automatic t_enable();
        logic [15:0] v;
        wr(2'd1, 16'hFFFF);
        rd(2'd1, v); check("R9 enable valid bits", v, 16'h1FBF);
        wr(2'd1, 16'h0080);
        rd(2'd1, v); check("R9 enable readback", v, 16'h0080);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        ev_rx_err = 1; tick(); ev_rx_err = 0;
        tick(); check("R10 masked no irq", {15'b0, irq}, 16'h0);
        ev_parity = 1; tick(); ev_parity = 0;
        check("R10 irq one cycle late", {15'b0, irq}, 16'h0);
        tick(); check("R10 irq high", {15'b0, irq}, 16'h1);
        rd(2'd0, v);
        check("R10 status latched unmasked", v, 16'h0180);
        check("R10 irq before clear seen", {15'b0, irq}, 16'h1);
        tick(); check("R10 irq drops", {15'b0, irq}, 16'h0);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_ignored();
        logic [15:0] v;
        ev_async_sent = 1; tick(); ev_async_sent = 0;
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hFFFF);
        rd(2'd2, v); check("R11 unmapped reads zero", v, 16'h0000);
        rd(2'd3, v); check("R11 unmapped reads zero", v, 16'h0000);
        rd(2'd0, v); check("R11 status write ignored", v, 16'h0800);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R11 status not set by write", v, 16'h0000);
    endtask

    bit done = 0;

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_pulses();
        t_avail();
        t_overflow();
        t_levels();
        t_txdone();
        t_same_cycle();
        t_enable();
        t_irq();
        t_ignored();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule